// File: doc/BRIEF.md
# Receiver Error and Interrupt Reporting

This block turns the per-subframe condition flags of a digital audio receiver into three host-facing signals. The first is a live error pin. Each source can be masked out of it. The pin is sampled again on every subframe strobe. The second is a frame-rate pin that reports only the faults that corrupt the sample itself. The third is an interrupt that stays asserted until the host has read the status.

The condition flags come from the line decoder and the clock-recovery loop. They arrive as a seven-bit vector, together with a subframe strobe and a frame strobe. The host supplies the error mask, the interrupt enables, the interrupt polarity and the drive mode. It reads the sticky status vector and pulses a read strobe to clear it. The interrupt can be driven push-pull or open-drain. Open-drain drive appears as an output-enable signal next to the interrupt level.

Top module: `rxerr_report`

## Requirements
- R1: The error pin `rx_err_o` changes only on a clock edge where `sf_stb_i` is high. At every other edge it holds its value.
- R2: On a clock edge with `sf_stb_i` high, `rx_err_o` takes the OR of all source flags whose mask bit is 0. The flag bits of `cond_i` are: bit 0 validity, bit 1 parity, bit 2 biphase, bit 3 confidence, bit 4 Q-CRC, bit 5 C-CRC, bit 6 PLL unlock. The flags are active high. A 1 in `err_mask_i` removes that source from the pin.
- R3: The error pin does not latch. A subframe strobe with no unmasked flag present drives it low at that same edge.
- R4: `nv_err_o` changes only on edges with `fr_stb_i` high. At such an edge it takes the OR of parity (bit 1), biphase (bit 2) and unlock (bit 6). It ignores validity, confidence, both CRC flags and `err_mask_i`.
- R5: Status bit i in `stat_o` sets at an edge where `sf_stb_i`, `cond_i[i]` and `irq_en_i[i]` are all high. A 1 in `irq_en_i` enables the source.
- R6: A status bit clears only on an edge where `rd_stb_i` is high. If a set event for a bit arrives at the same edge as the read, that bit stays set.
- R7: The interrupt is active in every cycle where `stat_o` is non-zero. Once active, it stays active until a read has returned every status bit to zero.
- R8: `irq_o` equals `irq_pol_i` while the interrupt is active and its inverse while inactive. `irq_pol_i` = 1 means active high.
- R9: With `irq_od_i` = 0 (push-pull), `irq_oe_o` is always 1. With `irq_od_i` = 1 (open-drain), `irq_oe_o` is 1 only while the interrupt is active.
- R10: While `rst_n` is low, both error pins are 0, `stat_o` is 0 and the interrupt is inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cond_i | input | 7 | Receiver condition flags, bit order as in R2 |
| sf_stb_i | input | 1 | One-cycle pulse per subframe |
| fr_stb_i | input | 1 | One-cycle pulse per frame |
| err_mask_i | input | 7 | Per-source mask for the error pin, 1 = ignored |
| irq_en_i | input | 7 | Per-source interrupt enable, 1 = enabled |
| rd_stb_i | input | 1 | Status-read pulse, clears the status |
| irq_pol_i | input | 1 | Interrupt level when active |
| irq_od_i | input | 1 | 1 = open-drain drive, 0 = push-pull |
| rx_err_o | output | 1 | Masked live error pin |
| nv_err_o | output | 1 | Frame-rate error pin, validity excluded |
| stat_o | output | 7 | Sticky interrupt status bits |
| irq_o | output | 1 | Interrupt level |
| irq_oe_o | output | 1 | Interrupt output enable |

## Verification
The bench walks every source through both mask states. A swapped bit index or inverted mask shows up as a pin that answers the wrong flag. Flags are raised between strobes, so a pin that sampled on every clock would move off the strobe. A pin that latched would stay high after an error-free subframe. The bench also pairs a read with a fresh event at the same edge. It holds status across many cycles with no read, and it sweeps all four polarity and drive combinations. A design that lets the read win would lose the event. One that cleared the interrupt early would drop it without a read. One that wired the output enable wrongly would float the pin while it is supposed to signal.

// File: rtl/rxerr_pkg.sv
package rxerr_pkg;
  localparam int unsigned RXE_NSRC = 7;
  localparam int unsigned SRC_VALID   = 0;
  localparam int unsigned SRC_PARITY  = 1;
  localparam int unsigned SRC_BIPHASE = 2;
  localparam int unsigned SRC_CONF    = 3;
  localparam int unsigned SRC_QCRC    = 4;
  localparam int unsigned SRC_CCRC    = 5;
  localparam int unsigned SRC_UNLOCK  = 6;

  typedef logic [RXE_NSRC-1:0] src_vec_t;

  // Any flag present whose mask bit is clear.
  function automatic logic any_unmasked(src_vec_t flags, src_vec_t mask);
    return |(flags & ~mask);
  endfunction

  // Sources that feed the frame-rate pin.
  function automatic src_vec_t frame_sel();
    src_vec_t s;
    s = '0;
    s[SRC_PARITY]  = 1'b1;
    s[SRC_BIPHASE] = 1'b1;
    s[SRC_UNLOCK]  = 1'b1;
    return s;
  endfunction

  function automatic logic frame_fault(src_vec_t flags);
    return |(flags & frame_sel());
  endfunction

  // One status bit: a set event wins over a clearing read.
  function automatic logic stat_next(logic cur, logic set, logic clr);
    return set | (cur & ~clr);
  endfunction
endpackage

// File: rtl/rxerr_sfpin.sv
module rxerr_sfpin
  import rxerr_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     sf_stb,
  input  src_vec_t flags,
  input  src_vec_t mask,
  output logic     err_q
);
  logic eval_now;
  assign eval_now = any_unmasked(flags, mask);

  always_ff @(posedge clk) begin
    if (!rst_n)      err_q <= 1'b0;
    else if (sf_stb) err_q <= eval_now;
  end
endmodule

// File: rtl/rxerr_frpin.sv
module rxerr_frpin
  import rxerr_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     fr_stb,
  input  src_vec_t flags,
  output logic     nv_q
);
  logic fault_now;
  assign fault_now = frame_fault(flags);

  always_ff @(posedge clk) begin
    if (!rst_n)      nv_q <= 1'b0;
    else if (fr_stb) nv_q <= fault_now;
  end
endmodule

// File: rtl/rxerr_stat.sv
module rxerr_stat
  import rxerr_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     sf_stb,
  input  src_vec_t flags,
  input  src_vec_t enable,
  input  logic     rd_stb,
  output src_vec_t stat_q,
  output logic     irq_act
);
  src_vec_t set_ev;
  src_vec_t stat_d;

  assign set_ev = sf_stb ? (flags & enable) : '0;

  for (genvar i = 0; i < RXE_NSRC; i++) begin : g_bit
    assign stat_d[i] = stat_next(stat_q[i], set_ev[i], rd_stb);
    always_ff @(posedge clk) begin
      if (!rst_n) stat_q[i] <= 1'b0;
      else        stat_q[i] <= stat_d[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq_act <= 1'b0;
    else        irq_act <= |stat_d;
  end
endmodule

// File: rtl/rxerr_irqdrv.sv
module rxerr_irqdrv (
  input  logic act,
  input  logic pol,
  input  logic od,
  output logic pin,
  output logic oe
);
  assign pin = act ? pol : ~pol;
  assign oe  = od ? act : 1'b1;
endmodule

// File: rtl/rxerr_report.sv
module rxerr_report
  import rxerr_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [RXE_NSRC-1:0] cond_i,
  input  logic                sf_stb_i,
  input  logic                fr_stb_i,
  input  logic [RXE_NSRC-1:0] err_mask_i,
  input  logic [RXE_NSRC-1:0] irq_en_i,
  input  logic                rd_stb_i,
  input  logic                irq_pol_i,
  input  logic                irq_od_i,
  output logic                rx_err_o,
  output logic                nv_err_o,
  output logic [RXE_NSRC-1:0] stat_o,
  output logic                irq_o,
  output logic                irq_oe_o
);
  logic irq_act;

  rxerr_sfpin u_sf (
    .clk(clk), .rst_n(rst_n), .sf_stb(sf_stb_i),
    .flags(cond_i), .mask(err_mask_i), .err_q(rx_err_o)
  );

  rxerr_frpin u_fr (
    .clk(clk), .rst_n(rst_n), .fr_stb(fr_stb_i),
    .flags(cond_i), .nv_q(nv_err_o)
  );

  rxerr_stat u_st (
    .clk(clk), .rst_n(rst_n), .sf_stb(sf_stb_i), .flags(cond_i),
    .enable(irq_en_i), .rd_stb(rd_stb_i), .stat_q(stat_o), .irq_act(irq_act)
  );

  rxerr_irqdrv u_drv (
    .act(irq_act), .pol(irq_pol_i), .od(irq_od_i),
    .pin(irq_o), .oe(irq_oe_o)
  );
endmodule

// File: rtl/rxerr_report_chk.sv
module rxerr_report_chk
  import rxerr_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic [RXE_NSRC-1:0] cond_i,
  input logic                sf_stb_i,
  input logic                fr_stb_i,
  input logic [RXE_NSRC-1:0] err_mask_i,
  input logic                rd_stb_i,
  input logic                irq_pol_i,
  input logic                irq_od_i,
  input logic                rx_err_o,
  input logic                nv_err_o,
  input logic [RXE_NSRC-1:0] stat_o,
  input logic                irq_o,
  input logic                irq_oe_o,
  input logic                irq_act
);
  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(sf_stb_i)) |-> $stable(rx_err_o)); // R1
  AST_ERR_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(sf_stb_i)) |-> (rx_err_o == $past(|(cond_i & ~err_mask_i)))); // R2
  AST_NV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(fr_stb_i)) |-> $stable(nv_err_o)); // R4
  AST_NV_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(fr_stb_i)) |->
      (nv_err_o == $past(cond_i[SRC_PARITY] | cond_i[SRC_BIPHASE] | cond_i[SRC_UNLOCK]))); // R4
  AST_STAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(rd_stb_i)) |-> (($past(stat_o) & ~stat_o) == '0)); // R6
  AST_IRQ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $fell(irq_act)) |-> $past(rd_stb_i)); // R7
  AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    irq_act |-> (irq_o == irq_pol_i)); // R8
  AST_PP_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_od_i |-> irq_oe_o); // R9
  AST_OD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_od_i && !irq_act) |-> !irq_oe_o); // R9
endmodule

bind rxerr_report rxerr_report_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cond_i(cond_i), .sf_stb_i(sf_stb_i),
  .fr_stb_i(fr_stb_i), .err_mask_i(err_mask_i), .rd_stb_i(rd_stb_i),
  .irq_pol_i(irq_pol_i), .irq_od_i(irq_od_i), .rx_err_o(rx_err_o),
  .nv_err_o(nv_err_o), .stat_o(stat_o), .irq_o(irq_o),
  .irq_oe_o(irq_oe_o), .irq_act(irq_act)
);

// File: tb/rxerr_report_bench.sv
module rxerr_report_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [6:0] cond = '0, mask = '0, ien = '0;
  logic sf = 1'b0, fr = 1'b0, rd = 1'b0, pol = 1'b1, od = 1'b0;
  logic rx_err, nv_err, irq, irq_oe;
  logic [6:0] stat;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // reference model state
  logic m_err = 1'b0, m_nv = 1'b0, m_irq = 1'b0;
  logic [6:0] m_stat = '0;

  always #5 clk = ~clk;

  rxerr_report u_rxerr_report (
    .clk(clk), .rst_n(rst_n), .cond_i(cond), .sf_stb_i(sf), .fr_stb_i(fr),
    .err_mask_i(mask), .irq_en_i(ien), .rd_stb_i(rd), .irq_pol_i(pol),
    .irq_od_i(od), .rx_err_o(rx_err), .nv_err_o(nv_err), .stat_o(stat),
    .irq_o(irq), .irq_oe_o(irq_oe)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference, updated on each edge
  always @(posedge clk) begin : model
    logic [6:0] nxt;
    logic any;
    if (!rst_n) begin
      m_err <= 1'b0; m_nv <= 1'b0; m_stat <= '0; m_irq <= 1'b0;
    end else begin
      if (sf) begin
        any = 1'b0;
        for (int i = 0; i < 7; i++) if (cond[i] && !mask[i]) any = 1'b1;
        m_err <= any;
      end
      if (fr) m_nv <= cond[1] || cond[2] || cond[6];
      nxt = rd ? 7'd0 : m_stat;
      if (sf) for (int i = 0; i < 7; i++) if (cond[i] && ien[i]) nxt[i] = 1'b1;
      m_stat <= nxt;
      m_irq <= (nxt != 7'd0);
    end
  end

  // Compare every cycle, away from the edge
  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      chk("R2 err pin", {7'd0, rx_err}, {7'd0, m_err});
      chk("R4 nv pin", {7'd0, nv_err}, {7'd0, m_nv});
      chk("R5 status", {1'b0, stat}, {1'b0, m_stat});
      chk("R8 irq level", {7'd0, irq}, {7'd0, m_irq ? pol : ~pol});
      chk("R9 irq enable", {7'd0, irq_oe}, {7'd0, od ? m_irq : 1'b1});
    end
  end

  task automatic step();
    @(posedge clk); #4;
  endtask

  task automatic clear_strobes();
    sf = 1'b0; fr = 1'b0; rd = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : main
    // R10 reset state with stimulus active
    cond = 7'h7f; sf = 1'b1; fr = 1'b1; ien = 7'h7f; pol = 1'b1; od = 1'b1;
    repeat (3) step();
    chk("R10 err", {7'd0, rx_err}, 8'd0);
    chk("R10 nv", {7'd0, nv_err}, 8'd0);
    chk("R10 stat", {1'b0, stat}, 8'd0);
    chk("R10 irq", {7'd0, irq}, 8'd0);
    chk("R10 oe", {7'd0, irq_oe}, 8'd0);
    cond = '0; clear_strobes(); ien = '0; od = 1'b0;
    rst_n = 1'b1;
    step();

    // R2 each source alone, unmasked then masked
    for (int i = 0; i < 7; i++) begin
      mask = '0; cond = 7'(1 << i); sf = 1'b1; step();
      chk("R2 unmasked source", {7'd0, rx_err}, 8'd1);
      mask = 7'(1 << i); step();
      chk("R2 masked source", {7'd0, rx_err}, 8'd0);
      sf = 1'b0; cond = '0; mask = '0;
    end

    // R1 flags between strobes do not move the pin
    cond = 7'h7f; repeat (3) step();
    chk("R1 hold low", {7'd0, rx_err}, 8'd0);
    sf = 1'b1; step(); sf = 1'b0;
    chk("R1 strobe raises", {7'd0, rx_err}, 8'd1);
    cond = '0; repeat (3) step();
    chk("R1 hold high", {7'd0, rx_err}, 8'd1);
    // R3 not latched
    sf = 1'b1; step(); sf = 1'b0;
    chk("R3 release", {7'd0, rx_err}, 8'd0);

    // R4 frame pin ignores validity, confidence, CRCs and mask
    mask = 7'h7f;
    cond = 7'b0111001; fr = 1'b1; step();
    chk("R4 ignored sources", {7'd0, nv_err}, 8'd0);
    foreach (cond[k]) begin
      if (k == 1 || k == 2 || k == 6) begin
        cond = 7'(1 << k); step();
        chk("R4 fault source", {7'd0, nv_err}, 8'd1);
        cond = '0; step();
        chk("R4 fault cleared", {7'd0, nv_err}, 8'd0);
      end
    end
    fr = 1'b0; cond = 7'h46; repeat (2) step();
    chk("R4 hold without strobe", {7'd0, nv_err}, 8'd0);
    cond = '0; mask = '0;

    // R5 set only for enabled sources; R7 hold without read
    ien = 7'h08; cond = 7'h7f; sf = 1'b1; step();
    sf = 1'b0; cond = '0;
    chk("R5 enabled bit only", {1'b0, stat}, 8'h08);
    chk("R7 irq active", {7'd0, irq}, 8'd1);
    repeat (6) step();
    chk("R7 irq held", {7'd0, irq}, 8'd1);
    // R6 event coincident with read keeps the bit
    ien = 7'h09; cond = 7'h08; sf = 1'b1; rd = 1'b1; step();
    clear_strobes(); cond = '0;
    chk("R6 set beats clear", {1'b0, stat}, 8'h08);
    chk("R7 still active", {7'd0, irq}, 8'd1);
    rd = 1'b1; step(); rd = 1'b0;
    chk("R6 read clears", {1'b0, stat}, 8'h00);
    chk("R7 released", {7'd0, irq}, 8'd0);

    // R8/R9 all polarity and drive combinations, idle and active
    for (int c = 0; c < 4; c++) begin
      pol = c[0]; od = c[1]; step();
      chk("R8 idle level", {7'd0, irq}, {7'd0, ~pol});
      chk("R9 idle enable", {7'd0, irq_oe}, {7'd0, ~od});
      cond = 7'h01; sf = 1'b1; ien = 7'h01; step(); sf = 1'b0; cond = '0;
      chk("R8 active level", {7'd0, irq}, {7'd0, pol});
      chk("R9 active enable", {7'd0, irq_oe}, 8'd1);
      rd = 1'b1; step(); rd = 1'b0;
    end

    // Mixed traffic against the model
    for (int n = 0; n < 3000; n++) begin
      cond = 7'($urandom); mask = 7'($urandom); ien = 7'($urandom);
      sf = ($urandom_range(0, 2) == 0); fr = ($urandom_range(0, 5) == 0);
      rd = ($urandom_range(0, 9) == 0);
      if ((n % 500) == 0) begin pol = 1'($urandom); od = 1'($urandom); end
      step();
    end
    clear_strobes();
    step();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule